// File: doc/BRIEF.md
# Bit-Serial Clock-Chip Register Access Master

This block lets on-chip logic reach the registers of an external real-time-clock device over a narrow parallel-pin link. The link has one bidirectional data line and three active-low controls: select, write strobe and read strobe. Every single bit travels in its own framed cycle. Select falls, then the strobe falls and is held, then the strobe rises, then select rises. A quiet gap follows before the next bit.

The host gives a one-cycle `start` together with an operation, a 4-bit register address and an 8-bit write value. There are four operations:
- **Register write:** the address, then the data byte.
- **Command:** the address alone.
- **Register read:** the address, then eight sampled bits.
- **Resynchronisation:** eight dummy reads that return the device's serial interface to the start of a transaction.

All strobe and gap lengths are counted in system clock cycles from a parameter that gives the number of clock cycles in one microsecond. While the block is working, `busy` is high. A one-cycle `done` marks the end of a transaction, and `rd_data` is valid in that cycle.

Top module: `rtc_serial_master`

## Requirements
- R1: After reset, and whenever `busy` is low, `sel_n`, `wstb_n` and `rstb_n` are high and the data pin is driven high (`dq_oe`=1, `dq_out`=1); `busy` and `done` are low.
- R2: Each transaction except resynchronisation first sends the 4 address bits as write-bit cycles, least significant bit first, with one write strobe per bit and `dq_out` holding the bit while the strobe is low.
- R3: A write (op code 0) to a non-command address sends 8 data bits after the address, least significant bit first, giving 12 write strobes in total.
- R4: An address whose bits 3 and 2 are both 1 (0xC to 0xF) is a command address. A write to such an address, or any command operation (op code 1), ends after the 4 address strobes and sends no data. A read is not shortened.
- R5: A read (op code 2) follows the address with 8 read-bit cycles. The data pin is sampled at the end of the first half of each read-strobe low time. The first sampled bit lands in `rd_data[0]` and the last in `rd_data[7]`, valid in the `done` cycle.
- R6: A resynchronisation (op code 3) performs exactly 8 read-bit cycles and no write cycles, and leaves `rd_data` unchanged.
- R7: A write strobe stays low for exactly CLK_PER_US cycles and a read strobe for exactly 2*CLK_PER_US cycles. Select is low whenever either strobe is low, and the two strobes are never low together.
- R8: During a read-bit cycle the data pin is released (`dq_oe`=0). During a write strobe it is driven (`dq_oe`=1).
- R9: Between the bit cycles of one transaction, select stays high for at least CLK_PER_US cycles.
- R10: `done` is a single-cycle pulse, and `busy` is low in that cycle. `busy` rises only in the cycle after an accepted `start`. A `start` while `busy` is high is ignored and causes no extra strobe and no extra `done`.
- R11: A `start` given in the same cycle as `done` is accepted, so transactions can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transaction |
| op | input | 2 | 0 write, 1 command, 2 read, 3 resynchronise |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Byte for a register write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | 8 | Byte read, valid with done |
| sel_n | output | 1 | Active-low device select |
| wstb_n | output | 1 | Active-low write strobe |
| rstb_n | output | 1 | Active-low read strobe |
| dq_out | output | 1 | Value driven on the data pin |
| dq_oe | output | 1 | Data pin output enable |
| dq_in | input | 1 | Value seen on the data pin |

## Verification
The two functions that can fall in one cycle are the end of a transaction (the `done` pulse) and the acceptance of a new request. The bench provokes this by raising `start` in the very cycle it sees `done`. It then judges the second transaction by its own strobe count, bit order and returned data. A second case places a request in the middle of a busy read: the bench checks that the request neither adds strobes nor produces a second `done`, and that `busy` stays low afterwards.

// File: rtl/rsm_pkg.sv
// Shared types for the bit-serial clock-chip master.
// Assumes: op code values are fixed by the host interface (see brief).
package rsm_pkg;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_CMD    = 2'd1,
        OP_READ   = 2'd2,
        OP_RESYNC = 2'd3
    } rsm_op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEL,
        PH_STB,
        PH_HOLD,
        PH_REL,
        PH_GAP
    } ph_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT
    } sq_state_e;

endpackage

// File: rtl/rsm_bit_engine.sv
// One framed bit cycle on the pins: select, strobe, release, gap.
// Assumes: go is a one-cycle pulse given only while the engine is idle;
// go_read and go_bit are valid with go. CLK_PER_US >= 1.
module rsm_bit_engine #(
    parameter int CLK_PER_US = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic go_read,
    input  logic go_bit,
    input  logic dq_in,
    output logic sel_n,
    output logic wstb_n,
    output logic rstb_n,
    output logic dq_out,
    output logic dq_oe,
    output logic rx_bit,
    output logic rx_valid,
    output logic bit_done
);
    import rsm_pkg::*;

    localparam int CW = $clog2(CLK_PER_US + 1);
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

    ph_state_e     state;
    logic [CW-1:0] cnt;
    logic          rd_q;
    logic          bit_q;
    logic          framed;

    // Phase sequencing and timing count for the current bit cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PH_IDLE;
            cnt      <= '0;
            rd_q     <= 1'b0;
            bit_q    <= 1'b1;
            rx_bit   <= 1'b0;
            rx_valid <= 1'b0;
            bit_done <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            bit_done <= 1'b0;
            case (state)
                PH_IDLE: begin
                    if (go) begin
                        rd_q  <= go_read;
                        bit_q <= go_bit;
                        state <= PH_SEL;
                    end
                end
                PH_SEL: begin
                    cnt   <= LAST;
                    state <= PH_STB;
                end
                PH_STB: begin
                    if (cnt == '0) begin
                        if (rd_q) begin
                            rx_bit   <= dq_in;
                            rx_valid <= 1'b1;
                            cnt      <= LAST;
                            state    <= PH_HOLD;
                        end else begin
                            state <= PH_REL;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) state <= PH_REL;
                    else           cnt   <= cnt - 1'b1;
                end
                PH_REL: begin
                    cnt   <= LAST;
                    state <= PH_GAP;
                end
                PH_GAP: begin
                    if (cnt == '0) begin
                        state    <= PH_IDLE;
                        bit_done <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    // Pin levels decoded from the phase register.
    always_comb begin
        framed = (state == PH_SEL) || (state == PH_STB) ||
                 (state == PH_HOLD) || (state == PH_REL);
        sel_n  = !framed;
        wstb_n = !((state == PH_STB) && !rd_q);
        rstb_n = !(((state == PH_STB) || (state == PH_HOLD)) && rd_q);
        dq_oe  = !(framed && rd_q);
        dq_out = (framed && !rd_q) ? bit_q : 1'b1;
    end

endmodule

// File: rtl/rsm_shift_unit.sv
// Holds the latched address and write byte, picks the bit to send,
// and assembles received bits with the first one ending in bit 0.
// Assumes: load is a one-cycle pulse at transaction acceptance.
module rsm_shift_unit #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int IW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              data_ph,
    input  logic [IW-1:0]     idx,
    input  logic              rx_valid,
    input  logic              rx_en,
    input  logic              rx_bit,
    output logic              tx_bit,
    output logic [DATA_W-1:0] rx_word
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Capture the request operands on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (load) begin
            addr_q  <= addr;
            wdata_q <= wr_data;
        end
    end

    // Shift received bits in from the top so the first lands in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (rx_valid && rx_en) begin
            rx_word <= {rx_bit, rx_word[DATA_W-1:1]};
        end
    end

    // Select the outgoing bit, least significant first.
    always_comb begin
        tx_bit = 1'b1;
        if (data_ph) begin
            for (int i = 0; i < DATA_W; i++)
                if (int'(idx) == i) tx_bit = wdata_q[i];
        end else begin
            for (int i = 0; i < ADDR_W; i++)
                if (int'(idx) == i) tx_bit = addr_q[i];
        end
    end

endmodule

// File: rtl/rsm_sequencer.sv
// Transaction control: accepts a request, steps through the address and
// data phases bit by bit, and raises done at the end.
// Assumes: bit_done arrives once per go; starts while busy are dropped.
module rsm_sequencer #(
    parameter int          ADDR_W      = 4,
    parameter int          DATA_W      = 8,
    parameter int          RESYNC_BITS = 8,
    parameter int          IW          = 4,
    parameter logic [ADDR_W-1:0] CMD_MASK  = 4'hC,
    parameter logic [ADDR_W-1:0] CMD_MATCH = 4'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bit_done,
    output logic              busy,
    output logic              done,
    output logic              load,
    output logic              go,
    output logic              go_read,
    output logic              data_ph,
    output logic [IW-1:0]     idx,
    output logic              rx_en
);
    import rsm_pkg::*;

    sq_state_e st;
    rsm_op_e   op_q;
    logic      with_data;
    logic [IW-1:0] last_idx;

    function automatic logic is_cmd(input logic [ADDR_W-1:0] a);
        return (a & CMD_MASK) == CMD_MATCH;
    endfunction

    // Index of the final bit in the current phase.
    always_comb begin
        if (!data_ph)                last_idx = IW'(ADDR_W - 1);
        else if (op_q == OP_RESYNC)  last_idx = IW'(RESYNC_BITS - 1);
        else                         last_idx = IW'(DATA_W - 1);
    end

    // Request acceptance and phase / bit stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SQ_IDLE;
            op_q      <= OP_WRITE;
            with_data <= 1'b0;
            data_ph   <= 1'b0;
            idx       <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        op_q      <= rsm_op_e'(op);
                        with_data <= (rsm_op_e'(op) == OP_READ) ||
                                     ((rsm_op_e'(op) == OP_WRITE) && !is_cmd(addr));
                        data_ph   <= (rsm_op_e'(op) == OP_RESYNC);
                        idx       <= '0;
                        st        <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: st <= SQ_WAIT;
                SQ_WAIT: begin
                    if (bit_done) begin
                        if (idx == last_idx) begin
                            if (!data_ph && with_data) begin
                                data_ph <= 1'b1;
                                idx     <= '0;
                                st      <= SQ_ISSUE;
                            end else begin
                                st   <= SQ_IDLE;
                                done <= 1'b1;
                            end
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= SQ_ISSUE;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Control strobes derived from the sequencing state.
    always_comb begin
        busy    = (st != SQ_IDLE);
        load    = (st == SQ_IDLE) && start;
        go      = (st == SQ_ISSUE);
        go_read = data_ph && ((op_q == OP_READ) || (op_q == OP_RESYNC));
        rx_en   = (op_q == OP_READ);
    end

endmodule

// File: rtl/rtc_serial_master.sv
// Top: host request interface to the bit-serial clock-chip pins.
// Assumes: dq_in is synchronous to clk or externally synchronised; the
// pad combines dq_out/dq_oe into the bidirectional pin.
module rtc_serial_master #(
    parameter int CLK_PER_US  = 8,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int RESYNC_BITS = 8,
    parameter logic [ADDR_W-1:0] CMD_MASK  = 4'hC,
    parameter logic [ADDR_W-1:0] CMD_MATCH = 4'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              sel_n,
    output logic              wstb_n,
    output logic              rstb_n,
    output logic              dq_out,
    output logic              dq_oe,
    input  logic              dq_in
);
    localparam int MAXB = (ADDR_W > DATA_W) ?
                          ((ADDR_W > RESYNC_BITS) ? ADDR_W : RESYNC_BITS) :
                          ((DATA_W > RESYNC_BITS) ? DATA_W : RESYNC_BITS);
    localparam int IW = $clog2(MAXB + 1);

    logic          load, go, go_read, data_ph, rx_en;
    logic [IW-1:0] idx;
    logic          tx_bit, rx_bit, rx_valid, bit_done;

    rsm_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESYNC_BITS(RESYNC_BITS),
        .IW(IW), .CMD_MASK(CMD_MASK), .CMD_MATCH(CMD_MATCH)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
        .bit_done(bit_done), .busy(busy), .done(done), .load(load),
        .go(go), .go_read(go_read), .data_ph(data_ph), .idx(idx),
        .rx_en(rx_en)
    );

    rsm_shift_unit #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IW(IW)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .addr(addr),
        .wr_data(wr_data), .data_ph(data_ph), .idx(idx),
        .rx_valid(rx_valid), .rx_en(rx_en), .rx_bit(rx_bit),
        .tx_bit(tx_bit), .rx_word(rd_data)
    );

    rsm_bit_engine #(
        .CLK_PER_US(CLK_PER_US)
    ) u_bit (
        .clk(clk), .rst_n(rst_n), .go(go), .go_read(go_read),
        .go_bit(tx_bit), .dq_in(dq_in), .sel_n(sel_n), .wstb_n(wstb_n),
        .rstb_n(rstb_n), .dq_out(dq_out), .dq_oe(dq_oe), .rx_bit(rx_bit),
        .rx_valid(rx_valid), .bit_done(bit_done)
    );

endmodule

// File: rtl/rsm_checker.sv
// Pin- and handshake-level properties for rtc_serial_master.
module rsm_checker #(
    parameter int CLK_PER_US = 8
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic sel_n,
    input logic wstb_n,
    input logic rstb_n,
    input logic dq_oe
);
    localparam int RW = $clog2(2 * CLK_PER_US + 2);

    logic [RW-1:0] w_run, r_run;

    // Length of the current low run of each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_run <= '0;
            r_run <= '0;
        end else begin
            w_run <= wstb_n ? '0 : w_run + 1'b1;
            r_run <= rstb_n ? '0 : r_run + 1'b1;
        end
    end

    a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sel_n && wstb_n && rstb_n && dq_oe));
    a_r7_wr_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wstb_n) |-> (w_run == RW'(CLK_PER_US)));
    a_r7_rd_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rstb_n) |-> (r_run == RW'(2 * CLK_PER_US)));
    a_r7_framed: assert property (@(posedge clk) disable iff (!rst_n)
        (!wstb_n || !rstb_n) |-> (!sel_n && (wstb_n || rstb_n)));
    a_r8_rd_released: assert property (@(posedge clk) disable iff (!rst_n)
        !rstb_n |-> !dq_oe);
    a_r8_wr_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !wstb_n |-> dq_oe);
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r10_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

bind rtc_serial_master rsm_checker #(.CLK_PER_US(CLK_PER_US)) u_rsm_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .sel_n(sel_n), .wstb_n(wstb_n), .rstb_n(rstb_n), .dq_oe(dq_oe)
);

// File: tb/test_rtc_serial_master.sv
`timescale 1ns/1ps
module test_rtc_serial_master;
    localparam int U = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] op = 2'd0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wr_data = 8'h00;
    logic       busy, done, sel_n, wstb_n, rstb_n, dq_out, dq_oe, dq_in;
    logic [7:0] rd_data;

    int tests = 0, fails = 0;
    bit finished = 0;

    // Bus monitor state (sampled on falling clock edge).
    int wr_cnt, rd_cnt, wr_len, rd_len, bad_len, gap_len, min_gap, done_cnt, oe_bad;
    logic [31:0] wr_bits;
    logic wr_prev = 1'b1, rd_prev = 1'b1, cs_prev = 1'b1, wr_hold = 1'b1;
    bit   seen_cs;
    logic [7:0] reply_q = 8'h00;

    always #2.5 clk = ~clk;

    rtc_serial_master #(.CLK_PER_US(U)) i_rtc_serial_master (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
        .wr_data(wr_data), .busy(busy), .done(done), .rd_data(rd_data),
        .sel_n(sel_n), .wstb_n(wstb_n), .rstb_n(rstb_n), .dq_out(dq_out),
        .dq_oe(dq_oe), .dq_in(dq_in)
    );

    // Device model: presents the next reply bit while the read strobe is low.
    assign dq_in = (!rstb_n && !sel_n) ? reply_q[rd_cnt % 8] : 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!wstb_n) begin wr_len++; wr_hold = dq_out; end
            else if (!wr_prev) begin
                if (wr_len != U) bad_len++;
                if (wr_cnt < 32) wr_bits[wr_cnt] = wr_hold;
                wr_cnt++; wr_len = 0;
            end
            if (!rstb_n) rd_len++;
            else if (!rd_prev) begin
                if (rd_len != 2 * U) bad_len++;
                rd_cnt++; rd_len = 0;
            end
            if (sel_n) gap_len++;
            else begin
                if (cs_prev && seen_cs && gap_len < min_gap) min_gap = gap_len;
                gap_len = 0; seen_cs = 1;
            end
            if ((!rstb_n && dq_oe) || (!wstb_n && !dq_oe)) oe_bad++;
            if (done) done_cnt++;
            wr_prev = wstb_n; rd_prev = rstb_n; cs_prev = sel_n;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_wr(input int o, input logic [3:0] a);
        case (o)
            0: return (a[3] && a[2]) ? 4 : 12;
            1: return 4;
            2: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_rd(input int o);
        return (o >= 2) ? 8 : 0;
    endfunction

    task automatic clear_mon();
        wr_cnt = 0; rd_cnt = 0; wr_len = 0; rd_len = 0; bad_len = 0;
        gap_len = 0; min_gap = 1000; done_cnt = 0; oe_bad = 0;
        wr_bits = '0; seen_cs = 0;
    endtask

    // Called just after a falling edge; issues a one-cycle start.
    task automatic launch(input int o, input logic [3:0] a, input logic [7:0] d,
                          input logic [7:0] rep);
        clear_mon();
        reply_q = rep;
        op = 2'(o); addr = a; wr_data = d; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        chk("R10", int'(busy), 1);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); #1; n++; end
        chk("R10", int'(done), 1);
    endtask

    task automatic judge(input int o, input logic [3:0] a, input logic [7:0] d,
                         input logic [7:0] rep, input logic [7:0] prev_rd);
        int ew = exp_wr(o, a);
        chk((ew == 12) ? "R3" : "R4", wr_cnt, ew);
        chk((o == 3) ? "R6" : "R5", rd_cnt, exp_rd(o));
        if (ew >= 4) chk("R2", int'(wr_bits[3:0]), int'(a));
        if (ew == 12) chk("R3", int'(wr_bits[11:4]), int'(d));
        if (o == 2) chk("R5", int'(rd_data), int'(rep));
        if (o == 3) chk("R6", int'(rd_data), int'(prev_rd));
        chk("R7", bad_len, 0);
        chk("R8", oe_bad, 0);
        if (ew + exp_rd(o) > 1) chk("R9", int'(min_gap >= U), 1);
        chk("R10", done_cnt, 1);
        chk("R10", int'(busy), 0);
    endtask

    task automatic run(input int o, input logic [3:0] a, input logic [7:0] d,
                       input logic [7:0] rep);
        logic [7:0] prev = rd_data;
        launch(o, a, d, rep);
        wait_done();
        judge(o, a, d, rep, prev);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] prev;
        void'($urandom(32'd2024));
        clear_mon();
        repeat (4) @(negedge clk);
        #1;
        // R1: reset state
        chk("R1", int'({sel_n, wstb_n, rstb_n, dq_out, dq_oe}), 5'h1F);
        chk("R1", int'({busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1", int'({sel_n, wstb_n, rstb_n, dq_out, dq_oe, busy}), 6'h3E);

        // Directed corner cases.
        run(3, 4'h0, 8'h00, 8'h5A);             // R6 resync before any read
        run(0, 4'hB, 8'hA5, 8'h00);             // R3 full write
        run(0, 4'hE, 8'h3C, 8'h00);             // R4 write to command address
        run(1, 4'h1, 8'hFF, 8'h00);             // R4 command op
        run(2, 4'hF, 8'h00, 8'h81);             // R5 read of command address
        run(2, 4'h0, 8'h00, 8'h33);             // R5
        run(3, 4'h7, 8'h00, 8'hC6);             // R6 keeps 0x33

        // R10: start while busy is ignored.
        launch(2, 4'h5, 8'h00, 8'h96);
        repeat (50) @(negedge clk);
        #1;
        op = 2'd0; addr = 4'h3; wr_data = 8'hEE; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        wait_done();
        chk("R10", wr_cnt, 4);
        chk("R10", int'(wr_bits[3:0]), 5);
        chk("R10", rd_cnt, 8);
        chk("R5", int'(rd_data), 8'h96);
        repeat (10) @(negedge clk);
        #1;
        chk("R10", int'(busy), 0);
        chk("R10", done_cnt, 1);

        // R11: start in the same cycle as done.
        prev = rd_data;
        launch(0, 4'h2, 8'h4D, 8'h00);
        wait_done();
        judge(0, 4'h2, 8'h4D, 8'h00, prev);
        launch(2, 4'h9, 8'h00, 8'hE1);
        wait_done();
        chk("R11", int'(rd_data), 8'hE1);
        chk("R11", wr_cnt, 4);
        chk("R11", int'(wr_bits[3:0]), 9);

        // Constrained random mix.
        for (int k = 0; k < 24; k++) begin
            int o = int'($urandom % 4);
            run(o, 4'($urandom), 8'($urandom), 8'($urandom));
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule